// File: doc/BRIEF.md
# Integrating Light-Sensor Conversion Controller

This block is the digital core of an integrating light-to-digital converter. Two photodiode front ends deliver one-cycle charge pulses. The core counts the pulses of a selected diode over an integration period and latches the count into a 16-bit result register. It can also count diode 1 and then diode 2 and latch their signed difference. The length of a period comes from one of two sources. In internal timing it is a fixed number of clock cycles that follows from the chosen resolution. In external timing the host frames it with sync commands.

A host reaches all configuration through a byte-wide register port with a write strobe and a combinational read path. A sticky interrupt flag is raised when a latched result leaves a programmed window. The flag also drives an interrupt pin. The core runs only while it is enabled and not powered down. Software should clear the enable bit before it sets power-down.

Top module: `lux_conv_core`

## Requirements
- R1: After reset, the command byte and the control byte read 0x00, the result is 0x0000, the lower threshold is 0x0000, the upper threshold is 0xFFFF and `irq_o` is low.
- R2: The register map is:
  - 0x0: command byte. Bit 7 enables the core, bit 6 powers it down, bit 5 selects external timing.
  - 0x1: control byte. Bit 5 is the flag, bits 3:2 select the diode, bits 1:0 set the width code.
  - 0x2 and 0x3: result, low byte then high byte.
  - 0x4 and 0x5: lower threshold, low byte then high byte.
  - 0x6 and 0x7: upper threshold, low byte then high byte.
  - 0x8: write-only strobe byte. Bit 0 is sync and bit 1 is clear. It reads as zero.
  
  Written bits read back unchanged.
- R3: The core is active only when enable is 1, power-down is 0 and the diode select is not 11. While it is inactive, the counters and the timer hold zero, the result and the flag do not change, and the registers keep their contents.
- R4: In internal timing, width codes 00, 01, 10 and 11 give resolutions n = 16, 12, 8 and 4. Each phase lasts 2^n active cycles, and the result register changes only at the end of a phase.
- R5: With select 00 (diode 1) or 01 (diode 2), the result is the unsigned number of pulses of that diode in the phase. A pulse in the last cycle of the phase is included. The count saturates at 2^n−1.
- R6: With select 10, a diode-1 phase is followed by a diode-2 phase of the same length. Each count saturates at 2^(n−1)−1. The result is diode 1 minus diode 2, in 16-bit two's complement.
- R7: In external timing, the first sync strobe after activation restarts the count. Each later sync strobe ends the phase and starts the next one. The cycle timer plays no part.
- R8: A sync strobe has no effect in internal timing.
- R9: The flag is set when a latched result is below the lower threshold or above the upper threshold, compared unsigned. The flag stays set until it is cleared, and `irq_o` follows it.
- R10: The flag is cleared by a clear strobe or by a control write with bit 5 = 0. Writing bit 5 = 1 does not set it. If a triggering latch and a clear fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| pd1_pulse | input | 1 | Diode 1 charge pulse |
| pd2_pulse | input | 1 | Diode 2 charge pulse |
| result_o | output | 16 | Latched conversion result |
| irq_o | output | 1 | Interrupt, mirrors the flag |

## Verification
The interrupt flag has two functions that can land on the same edge: a threshold-triggering latch can set it while a host clear resets it. The bench provokes this collision deliberately. It enables the core at a known edge with a 16-cycle phase, then issues a clear strobe timed to hit the sixteenth edge, and expects the flag to remain set. A second coincidence arises in external timing, where a diode pulse in the same cycle as the closing sync must be counted in the ending phase. The behavioural model judges both of these cycle by cycle.

// File: rtl/lux_pkg.sv
package lux_pkg;
  localparam int DW = 16;

  typedef enum logic [1:0] {
    SEL_D1   = 2'b00,
    SEL_D2   = 2'b01,
    SEL_DIFF = 2'b10,
    SEL_NONE = 2'b11
  } sel_e;

  localparam logic [3:0] A_CMD   = 4'h0;
  localparam logic [3:0] A_CTRL  = 4'h1;
  localparam logic [3:0] A_RES_L = 4'h2;
  localparam logic [3:0] A_RES_H = 4'h3;
  localparam logic [3:0] A_LO_L  = 4'h4;
  localparam logic [3:0] A_LO_H  = 4'h5;
  localparam logic [3:0] A_HI_L  = 4'h6;
  localparam logic [3:0] A_HI_H  = 4'h7;
  localparam logic [3:0] A_STB   = 4'h8;

  // last timer value of a phase: 2^n - 1 with n = 16 - 4*code
  function automatic logic [DW-1:0] phase_last(input logic [1:0] wcode);
    logic [4:0] n;
    n = 5'd16 - {1'b0, wcode, 2'b00};
    return DW'((17'd1 << n) - 17'd1);
  endfunction

  // saturation limit of a count; one bit less in difference mode
  function automatic logic [DW-1:0] count_limit(input logic [1:0] wcode, input logic diff);
    logic [4:0] n;
    n = 5'd16 - {1'b0, wcode, 2'b00} - {4'd0, diff};
    return DW'((17'd1 << n) - 17'd1);
  endfunction
endpackage

// File: rtl/lux_regs.sv
module lux_regs
  import lux_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [DW-1:0]     result,
  input  logic              flag_set,
  output logic              en,
  output logic              pd,
  output logic              ext,
  output logic [1:0]        sel,
  output logic [1:0]        wsel,
  output logic [DW-1:0]     lo_thr,
  output logic [DW-1:0]     hi_thr,
  output logic              flag,
  output logic              sync_stb,
  output logic [7:0]        rdata
);
  logic wr_cmd, wr_ctrl, wr_stb, clr;

  assign wr_cmd   = we && (addr == ADDR_W'(A_CMD));
  assign wr_ctrl  = we && (addr == ADDR_W'(A_CTRL));
  assign wr_stb   = we && (addr == ADDR_W'(A_STB));
  assign sync_stb = wr_stb && wdata[0];
  assign clr      = (wr_stb && wdata[1]) || (wr_ctrl && !wdata[5]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      pd     <= 1'b0;
      ext    <= 1'b0;
      sel    <= SEL_D1;
      wsel   <= 2'b00;
      lo_thr <= '0;
      hi_thr <= '1;
      flag   <= 1'b0;
    end else begin
      if (wr_cmd) begin
        en  <= wdata[7];
        pd  <= wdata[6];
        ext <= wdata[5];
      end
      if (wr_ctrl) begin
        sel  <= wdata[3:2];
        wsel <= wdata[1:0];
      end
      if (we && addr == ADDR_W'(A_LO_L)) lo_thr[7:0]  <= wdata;
      if (we && addr == ADDR_W'(A_LO_H)) lo_thr[15:8] <= wdata;
      if (we && addr == ADDR_W'(A_HI_L)) hi_thr[7:0]  <= wdata;
      if (we && addr == ADDR_W'(A_HI_H)) hi_thr[15:8] <= wdata;
      // a fresh trigger outranks a clear on the same edge
      if (flag_set)  flag <= 1'b1;
      else if (clr)  flag <= 1'b0;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_W'(A_CMD):   rdata = {en, pd, ext, 5'b0};
      ADDR_W'(A_CTRL):  rdata = {2'b0, flag, 1'b0, sel, wsel};
      ADDR_W'(A_RES_L): rdata = result[7:0];
      ADDR_W'(A_RES_H): rdata = result[15:8];
      ADDR_W'(A_LO_L):  rdata = lo_thr[7:0];
      ADDR_W'(A_LO_H):  rdata = lo_thr[15:8];
      ADDR_W'(A_HI_L):  rdata = hi_thr[7:0];
      ADDR_W'(A_HI_H):  rdata = hi_thr[15:8];
      default:          rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/lux_seq.sv
module lux_seq
  import lux_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          ext,
  input  logic [1:0]    wsel,
  input  logic          sync_stb,
  output logic [DW-1:0] timer,
  output logic          phase_end
);
  logic          armed;
  logic [DW-1:0] last;

  assign last      = phase_last(wsel);
  assign phase_end = active && (ext ? (sync_stb && armed) : (timer == last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer <= '0;
      armed <= 1'b0;
    end else if (!active) begin
      timer <= '0;
      armed <= 1'b0;
    end else begin
      timer <= (ext || timer == last) ? '0 : timer + 1'b1;
      armed <= ext && (armed || sync_stb);
    end
  end
endmodule

// File: rtl/lux_accum.sv
module lux_accum
  import lux_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic [1:0]    sel,
  input  logic [1:0]    wsel,
  input  logic          pd1_pulse,
  input  logic          pd2_pulse,
  input  logic          phase_end,
  input  logic          restart,
  output logic          latch,
  output logic [DW-1:0] new_val,
  output logic [DW-1:0] result
);
  logic          diff, phase, src;
  logic [DW-1:0] cnt, d1_cnt, lim, cnt_eff;

  assign diff    = (sel == SEL_DIFF);
  assign lim     = count_limit(wsel, diff);
  assign src     = (sel == SEL_D2 || (diff && phase)) ? pd2_pulse : pd1_pulse;
  assign cnt_eff = (cnt == lim) ? cnt : cnt + {{(DW-1){1'b0}}, src};
  assign latch   = phase_end && !(diff && !phase);
  assign new_val = diff ? d1_cnt - cnt_eff : cnt_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      d1_cnt <= '0;
      phase  <= 1'b0;
      result <= '0;
    end else if (!active) begin
      cnt    <= '0;
      d1_cnt <= '0;
      phase  <= 1'b0;
    end else if (phase_end) begin
      cnt <= '0;
      if (latch) begin
        result <= new_val;
        phase  <= 1'b0;
      end else begin
        d1_cnt <= cnt_eff;
        phase  <= 1'b1;
      end
    end else if (restart) begin
      cnt <= '0;
    end else begin
      cnt <= cnt_eff;
    end
  end
endmodule

// File: rtl/lux_conv_core.sv
module lux_conv_core
  import lux_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              pd1_pulse,
  input  logic              pd2_pulse,
  output logic [DW-1:0]     result_o,
  output logic              irq_o
);
  logic          en, pd, ext, flag, sync_stb, active;
  logic          phase_end, restart, latch, flag_set;
  logic [1:0]    sel, wsel;
  logic [DW-1:0] lo_thr, hi_thr, new_val, timer;

  assign active   = en && !pd && (sel != SEL_NONE);
  assign restart  = active && ext && sync_stb;
  assign flag_set = latch && ((new_val < lo_thr) || (new_val > hi_thr));
  assign irq_o    = flag;

  lux_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .result(result_o), .flag_set(flag_set), .en(en), .pd(pd), .ext(ext),
    .sel(sel), .wsel(wsel), .lo_thr(lo_thr), .hi_thr(hi_thr), .flag(flag),
    .sync_stb(sync_stb), .rdata(reg_rdata)
  );

  lux_seq u_seq (
    .clk(clk), .rst_n(rst_n), .active(active), .ext(ext), .wsel(wsel),
    .sync_stb(sync_stb), .timer(timer), .phase_end(phase_end)
  );

  lux_accum u_accum (
    .clk(clk), .rst_n(rst_n), .active(active), .sel(sel), .wsel(wsel),
    .pd1_pulse(pd1_pulse), .pd2_pulse(pd2_pulse), .phase_end(phase_end),
    .restart(restart), .latch(latch), .new_val(new_val), .result(result_o)
  );
endmodule

// File: rtl/lux_conv_core_chk.sv
module lux_conv_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        active,
  input logic        ext,
  input logic [1:0]  wsel,
  input logic        sync_stb,
  input logic        phase_end,
  input logic [15:0] timer,
  input logic [15:0] result_o,
  input logic        irq_o,
  input logic        reg_we,
  input logic [3:0]  reg_addr,
  input logic [7:0]  reg_wdata
);
  logic [4:0]  n_bits;
  logic [15:0] t_last;
  assign n_bits = 5'd16 - {1'b0, wsel, 2'b00};
  assign t_last = 16'((17'd1 << n_bits) - 17'd1);

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(result_o));

  assert_idle_timer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (timer == 16'd0));

  assert_latch_at_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> $past(phase_end));

  assert_sync_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ext && sync_stb && timer != t_last) |=> $stable(result_o));

  assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(phase_end));

  assert_irq_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(reg_we && ((reg_addr == 4'h8 && reg_wdata[1]) ||
                                      (reg_addr == 4'h1 && !reg_wdata[5]))));
endmodule

bind lux_conv_core lux_conv_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .ext(ext), .wsel(wsel),
  .sync_stb(sync_stb), .phase_end(phase_end), .timer(timer),
  .result_o(result_o), .irq_o(irq_o), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata)
);

// File: tb/lux_conv_core_test.sv
`timescale 1ns/1ps
module lux_conv_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic        pd1_pulse = 1'b0;
  logic        pd2_pulse = 1'b0;
  logic [15:0] result_o;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  int pat = 0;
  logic [7:0] lfsr = 8'h5A;

  always #2.5 clk = ~clk;

  lux_conv_core uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pd1_pulse(pd1_pulse),
    .pd2_pulse(pd2_pulse), .result_o(result_o), .irq_o(irq_o)
  );

  // behavioural reference state
  int m_en, m_pd, m_ext, m_sel, m_w, m_flag, m_lo, m_hi;
  int m_tmr, m_arm, m_cnt, m_ph, m_d1, m_res;

  function automatic int exp_rd(input int a);
    case (a)
      0: return (m_en << 7) | (m_pd << 6) | (m_ext << 5);
      1: return (m_flag << 5) | (m_sel << 2) | m_w;
      2: return m_res & 255;
      3: return (m_res >> 8) & 255;
      4: return m_lo & 255;
      5: return (m_lo >> 8) & 255;
      6: return m_hi & 255;
      7: return (m_hi >> 8) & 255;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int act, n, plen, lim, src, ce, pend, rst_cnt, setf, clr, sync, nv;
    if (!rst_n) begin
      m_en = 0; m_pd = 0; m_ext = 0; m_sel = 0; m_w = 0; m_flag = 0;
      m_lo = 0; m_hi = 16'hFFFF; m_tmr = 0; m_arm = 0; m_cnt = 0;
      m_ph = 0; m_d1 = 0; m_res = 0;
    end else begin
      act  = (m_en && !m_pd && m_sel != 3) ? 1 : 0;
      n    = 16 - 4 * m_w;
      plen = 1 << n;
      lim  = (m_sel == 2) ? (1 << (n - 1)) - 1 : plen - 1;
      sync = (reg_we && reg_addr == 4'h8 && reg_wdata[0]) ? 1 : 0;
      clr  = ((reg_we && reg_addr == 4'h8 && reg_wdata[1]) ||
              (reg_we && reg_addr == 4'h1 && !reg_wdata[5])) ? 1 : 0;
      src  = (m_sel == 1 || (m_sel == 2 && m_ph == 1)) ? int'(pd2_pulse) : int'(pd1_pulse);
      ce   = (m_cnt >= lim) ? lim : m_cnt + src;
      pend = act && (m_ext ? (sync && m_arm) : (m_tmr == plen - 1));
      rst_cnt = act && m_ext && sync;
      setf = 0;
      if (!act) begin
        m_cnt = 0; m_ph = 0; m_d1 = 0; m_tmr = 0; m_arm = 0;
      end else begin
        if (pend) begin
          if (m_sel == 2 && m_ph == 0) begin
            m_d1 = ce; m_ph = 1;
          end else begin
            nv = (m_sel == 2) ? ((m_d1 - ce) & 16'hFFFF) : ce;
            m_res = nv; m_ph = 0;
            setf = (nv < m_lo || nv > m_hi) ? 1 : 0;
          end
          m_cnt = 0;
        end else if (rst_cnt) m_cnt = 0;
        else m_cnt = ce;
        m_tmr = (m_ext || m_tmr == plen - 1) ? 0 : m_tmr + 1;
        m_arm = m_ext ? (m_arm | sync) : 0;
      end
      if (setf) m_flag = 1;
      else if (clr) m_flag = 0;
      if (reg_we) begin
        case (reg_addr)
          4'h0: begin m_en = reg_wdata[7]; m_pd = reg_wdata[6]; m_ext = reg_wdata[5]; end
          4'h1: begin m_sel = reg_wdata[3:2]; m_w = reg_wdata[1:0]; end
          4'h4: m_lo = (m_lo & 16'hFF00) | reg_wdata;
          4'h5: m_lo = (m_lo & 16'h00FF) | (reg_wdata << 8);
          4'h6: m_hi = (m_hi & 16'hFF00) | reg_wdata;
          4'h7: m_hi = (m_hi & 16'h00FF) | (reg_wdata << 8);
          default: ;
        endcase
      end
    end
    #1;
    if (rst_n) begin
      check(result_o == 16'(m_res), "R4 result", result_o, m_res);
      check(irq_o == m_flag[0], "R9 irq", irq_o, m_flag);
    end
  end

  always @(negedge clk) begin
    if (pat != 0) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      pd1_pulse = lfsr[0];
      pd2_pulse = lfsr[3];
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input string req);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    check(reg_rdata == 8'(exp_rd(a)), req, reg_rdata, exp_rd(a));
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    wait_cyc(3);
    rst_n = 1'b1;
    // R1: reset values
    for (int a = 0; a < 8; a++) rd(4'(a), "R1 reset readback");
    check(result_o == 16'h0 && irq_o == 1'b0, "R1 outputs", {irq_o, result_o}, 0);
    // R2: thresholds and readback
    wr(4'h4, 8'h03); wr(4'h5, 8'h00); wr(4'h6, 8'h0A); wr(4'h7, 8'h00);
    for (int a = 4; a < 8; a++) rd(4'(a), "R2 threshold readback");
    rd(4'h8, "R2 strobe reads zero");
    // R5/R9: diode 1, width 4, saturating
    wr(4'h1, 8'h03); pd1_pulse = 1'b1;
    wr(4'h0, 8'h80);
    wait_cyc(40);
    check(result_o == 16'd15, "R5 saturation", result_o, 15);
    check(irq_o == 1'b1, "R9 above upper", irq_o, 1);
    // R10: clear paths
    wr(4'h0, 8'h00); wr(4'h8, 8'h02);
    check(irq_o == 1'b0, "R10 strobe clear", irq_o, 0);
    wr(4'h1, 8'h23);
    check(irq_o == 1'b0, "R10 write one no set", irq_o, 0);
    wr(4'h0, 8'h80); wait_cyc(20); wr(4'h0, 8'h00);
    check(irq_o == 1'b1, "R9 sticky", irq_o, 1);
    wr(4'h1, 8'h03);
    check(irq_o == 1'b0, "R10 ctrl clear", irq_o, 0);
    // R5: diode 2 only, random pulses, width 8
    wr(4'h1, 8'h06); pat = 1; wr(4'h0, 8'h80); wait_cyc(600);
    // R4: width 12 and width 16
    wr(4'h0, 8'h00); wr(4'h1, 8'h01); wr(4'h0, 8'h80); wait_cyc(4200);
    wr(4'h0, 8'h00); pat = 0; pd1_pulse = 1'b1; pd2_pulse = 1'b0;
    wr(4'h1, 8'h00); wr(4'h0, 8'h80); wait_cyc(65540);
    check(result_o == 16'hFFFF, "R4 width 16 full count", result_o, 16'hFFFF);
    // R6: subtract mode
    wr(4'h0, 8'h00); wr(4'h1, 8'h0B); wr(4'h0, 8'h80); wait_cyc(40);
    check(result_o == 16'd7, "R6 positive difference", result_o, 7);
    pd1_pulse = 1'b0; pd2_pulse = 1'b1; wait_cyc(70);
    check(result_o == 16'hFFF9, "R6 negative difference", result_o, 16'hFFF9);
    pat = 1; wait_cyc(300); pat = 0;
    // R3: no-op select and power-down
    wr(4'h0, 8'h00); pd1_pulse = 1'b1; pd2_pulse = 1'b1;
    wr(4'h1, 8'h0F); wr(4'h0, 8'h80); held = result_o; wait_cyc(50);
    check(result_o == held, "R3 no-op select", result_o, held);
    wr(4'h1, 8'h03); wr(4'h0, 8'hC0); wait_cyc(50);
    check(result_o == held, "R3 power-down holds", result_o, held);
    rd(4'h0, "R3 command retained"); rd(4'h1, "R3 control retained");
    rd(4'h6, "R3 threshold retained");
    // R8: sync in internal timing
    wr(4'h0, 8'h00); pd2_pulse = 1'b0; wr(4'h1, 8'h02); wr(4'h0, 8'h80);
    wait_cyc(5); held = result_o; wr(4'h8, 8'h01); wait_cyc(5);
    check(result_o == held, "R8 sync ignored", result_o, held);
    // R7: external timing, 22 edges between strobes
    wr(4'h0, 8'h00); wr(4'h0, 8'hA0); wait_cyc(10);
    wr(4'h8, 8'h01); wait_cyc(20); wr(4'h8, 8'h01);
    check(result_o == 16'd22, "R7 framed count", result_o, 22);
    wait_cyc(300);
    check(result_o == 16'd22, "R7 timer unused", result_o, 22);
    // R10: trigger and clear on the same edge
    wr(4'h0, 8'h00); wr(4'h8, 8'h02); wr(4'h1, 8'h03);
    wr(4'h0, 8'h80); wait_cyc(14); wr(4'h8, 8'h02);
    check(irq_o == 1'b1, "R10 set beats clear", irq_o, 1);
    wait_cyc(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule